// File: doc/BRIEF.md
# Dual-Slot Clause 22 Management Master

This block drives the two-wire PHY management bus (MDC clock, bidirectional MDIO data) on behalf of a memory-mapped host. It builds complete Clause 22 read and write frames, so the host never handles the serial protocol. Any of 32 PHYs can be reached because the PHY address is 5 bits wide.

Two address slots each hold the address of one PHY. Each slot maps that PHY's 32 registers into its own window of the host address space. A host read or write inside a window runs one frame to the PHY named by the matching slot. The word offset within the window gives the register number. The host holds the bus access while waitrequest is high, for as long as the frame lasts. A slot keeps its value, so repeated accesses to the same two PHYs need no address write before each one.

Host word map, decoded from the two top address bits: region 0 holds the slots, region 1 is window 0, region 2 is window 1, and region 3 is unused.

Top module: `mdio_dual_master`

## Requirements
- R1: After reset, MDC is low, MDIO is released (`mdio_oe` low), `hb_waitreq` is low, and both slots read 0.
- R2: Word offsets 0x00 and 0x01 hold slot 0 and slot 1. Bits 4:0 carry the PHY address and upper read bits are zero. These registers respond with no wait state.
- R3: Offsets 0x20–0x3F form window 0 and 0x40–0x5F form window 1. Address bits 4:0 give the register number, and the PHY address is taken from slot 0 or slot 1 respectively.
- R4: A window write emits, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY, 5-bit register, turnaround 10, then the 16 write-data bits. The master drives MDIO for all 64 bits.
- R5: A window read emits opcode 10. The master drives MDIO through bit 45 and releases it from the first turnaround bit (bit 46) to the end of the frame.
- R6: Read data is sampled on the rising MDC edges of frame bits 48–63, MSB first, and returned on `hb_rdata[15:0]`.
- R7: MDC runs only during a frame, with a period of 2×`MDC_HALF` system clocks. MDIO changes only at a falling MDC edge or at frame start.
- R8: A window access holds `hb_waitreq` high for exactly 128×`MDC_HALF`+1 rising clock edges. It completes on the next edge, with any read data valid in that cycle.
- R9: A slot keeps its value across any number of window accesses. Every access to a window uses the slot's current value without the slot being rewritten.
- R10: Region 0 offsets 0x02–0x1F and all of region 3 (0x60–0x7F) complete with no wait. They read 0, start no frame, and writes to them change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_addr | input | 7 | Host word address |
| hb_read | input | 1 | Host read request |
| hb_write | input | 1 | Host write request |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data |
| hb_waitreq | output | 1 | Host stall while a frame runs |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO line value as seen by the master |

## Verification
A bench PHY model captures every frame bit on rising MDC edges and answers reads with a value computed from the decoded PHY and register fields. The sweep reads every register number through both windows with two distinct slot values. A mix-up between the windows, or a wrong register field, therefore shows up as a wrong captured header or wrong returned data. Writes use all-zero, all-one and alternating data, which separates bit-order errors from stuck bits. Reloading the slots with the extreme addresses 0 and 31, and probing unused offsets, shows that the slots persist and that dead addresses have no side effects.

// File: rtl/mdio_dual_pkg.sv
package mdio_dual_pkg;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = REG_AW + 2;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  // Complete serial image, bit 63 goes out first.
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              is_rd,
    input logic [PHY_AW-1:0] phy,
    input logic [REG_AW-1:0] ra,
    input logic [DATA_W-1:0] wd
  );
    return {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, ra, 2'b10,
            (is_rd ? {DATA_W{1'b1}} : wd)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CW'(HALF - 1));
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  mdc_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise || fall) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_in,
  input  logic [PHY_AW-1:0] phy,
  input  logic [REG_AW-1:0] ra,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic                 is_rd;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     idx_nx;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] img;

  assign idx_nx = idx + 1'b1;
  assign img    = build_frame(rd_in, phy, ra, wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      is_rd   <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        is_rd   <= rd_in;
        idx     <= '0;
        shreg   <= img;
        mdio_o  <= img[FRAME_LEN-1];
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise && is_rd && (idx >= IDX_W'(DATA_IDX)))
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            idx     <= idx_nx;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
            mdio_o  <= shreg[FRAME_LEN-2];
            mdio_oe <= !(is_rd && (idx_nx >= IDX_W'(TA_IDX)));
          end
        end
      end
    end
  end

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !mdio_oe);
  // R7
  mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall) |=> $stable(mdio_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mdio_slot_regs.sv
module mdio_slot_regs #(
  parameter int NSLOT = 2,
  parameter int AW    = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [$clog2(NSLOT)-1:0]      sel,
  input  logic [AW-1:0]                 din,
  output logic [NSLOT-1:0][AW-1:0]      slots
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[g] <= '0;
      else if (we && (sel == g))
        slots[g] <= din;
    end
  end
endmodule

// File: rtl/mdio_dual_master.sv
module mdio_dual_master
  import mdio_dual_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic              hb_read,
  input  logic              hb_write,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  output logic              hb_waitreq,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [1:0] RGN_SLOT = 2'd0;
  localparam logic [1:0] RGN_WIN0 = 2'd1;
  localparam logic [1:0] RGN_WIN1 = 2'd2;

  logic [1:0]             region;
  logic                   acc;
  logic                   win_acc;
  logic                   slot_hit;
  logic                   eng_start;
  logic                   eng_busy;
  logic                   eng_done;
  logic                   mdc_rise;
  logic                   mdc_fall;
  logic [DATA_W-1:0]      eng_rdata;
  logic [PHY_AW-1:0]      cur_phy;
  logic [1:0][PHY_AW-1:0] slots;

  assign region    = hb_addr[ADDR_W-1 -: 2];
  assign acc       = hb_read || hb_write;
  assign win_acc   = acc && ((region == RGN_WIN0) || (region == RGN_WIN1));
  assign slot_hit  = (region == RGN_SLOT) && (hb_addr[REG_AW-1:1] == '0);
  assign eng_start = win_acc && !eng_busy && !eng_done;
  assign cur_phy   = (region == RGN_WIN1) ? slots[1] : slots[0];

  assign hb_waitreq = win_acc && !eng_done;

  always_comb begin
    hb_rdata = '0;
    if (region == RGN_WIN0 || region == RGN_WIN1)
      hb_rdata = eng_rdata;
    else if (slot_hit)
      hb_rdata = DATA_W'(slots[hb_addr[0]]);
  end

  mdio_slot_regs #(.NSLOT(2), .AW(PHY_AW)) u_slots (
    .clk   (clk),
    .rst   (rst),
    .we    (hb_write && slot_hit),
    .sel   (hb_addr[0]),
    .din   (hb_wdata[PHY_AW-1:0]),
    .slots (slots)
  );

  mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk  (clk),
    .rst  (rst),
    .run  (eng_busy),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .rd_in   (hb_read),
    .phy     (cur_phy),
    .ra      (hb_addr[REG_AW-1:0]),
    .wdata   (hb_wdata),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdio_i  (mdio_i),
    .busy    (eng_busy),
    .done    (eng_done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rdata   (eng_rdata)
  );

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> $stable(slots));
  // R7
  mdc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !mdc);
endmodule

// File: tb/mdio_dual_master_tb.sv
module mdio_dual_master_tb;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  hb_addr = '0;
  logic        hb_read = 1'b0;
  logic        hb_write = 1'b0;
  logic [15:0] hb_wdata = '0;
  logic [15:0] hb_rdata;
  logic        hb_waitreq;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_line;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_dual_master #(.MDC_HALF(H)) u_dut (
    .clk(clk), .rst(rst), .hb_addr(hb_addr), .hb_read(hb_read),
    .hb_write(hb_write), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_waitreq(hb_waitreq), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  // PHY model
  longint      cyc = 0;
  longint      last_rise = 0;
  int          nrise = 0;
  logic [63:0] cap = '0;
  bit          fr_read = 0;
  bit          period_err = 0;
  bit          oe_err = 0;
  logic [15:0] resp = '0;

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2A} ^ {r, 3'b101, p, 3'b011};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    if (nrise > 0 && (cyc - last_rise) != 2 * H) period_err = 1;
    last_rise = cyc;
    if (fr_read && nrise >= 46 && mdio_oe) oe_err = 1;
    if ((!fr_read || nrise < 46) && !mdio_oe) oe_err = 1;
    cap = {cap[62:0], mdio_line};
    nrise = nrise + 1;
    if (nrise == 36) fr_read = (cap[1:0] == 2'b10);
    if (nrise == 46) resp = phy_val(cap[9:5], cap[4:0]);
  end

  always @(negedge mdc) begin
    if (fr_read) begin
      if (nrise == 47) begin phy_en = 1; phy_bit = 0; end
      else if (nrise >= 48 && nrise <= 63) phy_bit = resp[63 - nrise];
      else if (nrise >= 64) phy_en = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [6:0] a, input bit wr, input logic [15:0] d,
                     output logic [15:0] q, output int waits);
    nrise = 0; fr_read = 0; period_err = 0; oe_err = 0; phy_en = 0; cap = '0;
    @(negedge clk);
    hb_addr = a; hb_write = wr; hb_read = !wr; hb_wdata = d;
    #1;
    waits = 0;
    while (hb_waitreq && !finished) begin
      @(posedge clk); @(negedge clk);
      waits++;
    end
    q = hb_rdata;
    @(posedge clk); @(negedge clk);
    hb_read = 0; hb_write = 0;
  endtask

  logic [4:0] shadow [2];

  task automatic win_op(input int w, input logic [4:0] r, input bit wr, input logic [15:0] d);
    logic [15:0] q;
    int          waits;
    logic [4:0]  p;
    logic [63:0] exp;
    logic [15:0] rv;
    p  = shadow[w];
    rv = phy_val(p, r);
    exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, (wr ? d : rv)};
    bus((w == 0 ? 7'h20 : 7'h40) | {2'b00, r}, wr, d, q, waits);
    chk(cap == exp, wr ? "R4 R3 R9 write frame" : "R5 R3 R9 read frame", cap, exp);
    chk(nrise == 64, "R7 rising edge count", 64'(nrise), 64);
    chk(!period_err, "R7 MDC period", 64'(period_err), 0);
    chk(!oe_err, wr ? "R4 drive enable" : "R5 release at turnaround", 64'(oe_err), 0);
    chk(waits == 128 * H + 1, "R8 waitrequest length", 64'(waits), 64'(128 * H + 1));
    if (!wr) chk(q == rv, "R6 read data", 64'(q), 64'(rv));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int          waits;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1
    chk(mdc == 0, "R1 mdc low", 64'(mdc), 0);
    chk(mdio_oe == 0, "R1 released", 64'(mdio_oe), 0);
    chk(hb_waitreq == 0, "R1 waitreq low", 64'(hb_waitreq), 0);
    bus(7'h00, 0, 16'h0, q, waits);
    chk(q == 0, "R1 slot0 reset", 64'(q), 0);
    bus(7'h01, 0, 16'h0, q, waits);
    chk(q == 0, "R1 slot1 reset", 64'(q), 0);

    // R2
    bus(7'h00, 1, 16'hFFF3, q, waits);
    chk(waits == 0, "R2 no wait", 64'(waits), 0);
    bus(7'h01, 1, 16'h000C, q, waits);
    shadow[0] = 5'h13; shadow[1] = 5'h0C;
    bus(7'h00, 0, 16'h0, q, waits);
    chk(q == 16'h0013, "R2 slot0 readback", 64'(q), 64'h13);
    bus(7'h01, 0, 16'h0, q, waits);
    chk(q == 16'h000C, "R2 slot1 readback", 64'(q), 64'h0C);

    // R3 R5 R6 R9: every register through both windows
    for (int r = 0; r < 32; r++) begin
      win_op(0, 5'(r), 0, 16'h0);
      win_op(1, 5'(r), 0, 16'h0);
    end

    // R4: data patterns
    win_op(0, 5'd0,  1, 16'h0000);
    win_op(0, 5'd31, 1, 16'hFFFF);
    win_op(1, 5'd10, 1, 16'hA5C3);
    win_op(1, 5'd21, 1, 16'h5A3C);
    win_op(0, 5'd7,  1, 16'h8001);

    // R9: reload slots with extremes, windows follow
    bus(7'h01, 1, 16'h001F, q, waits);
    bus(7'h00, 1, 16'h0000, q, waits);
    shadow[0] = 5'h00; shadow[1] = 5'h1F;
    win_op(1, 5'd31, 0, 16'h0);
    win_op(0, 5'd0,  0, 16'h0);
    win_op(0, 5'd31, 1, 16'hFFFF);
    win_op(1, 5'd16, 1, 16'h1234);

    // R10: dead offsets
    bus(7'h62, 1, 16'h0005, q, waits);
    chk(waits == 0 && nrise == 0, "R10 region3 write no frame", 64'(waits + nrise), 0);
    bus(7'h05, 1, 16'h0007, q, waits);
    chk(waits == 0 && nrise == 0, "R10 region0 spare write no frame", 64'(waits + nrise), 0);
    bus(7'h7F, 0, 16'h0, q, waits);
    chk(q == 0 && waits == 0, "R10 region3 reads zero", 64'(q), 0);
    bus(7'h03, 0, 16'h0, q, waits);
    chk(q == 0, "R10 spare slot offset reads zero", 64'(q), 0);
    bus(7'h00, 0, 16'h0, q, waits);
    chk(q == 16'h0000, "R10 slot0 untouched", 64'(q), 0);
    bus(7'h01, 0, 16'h0, q, waits);
    chk(q == 16'h001F, "R10 slot1 untouched", 64'(q), 64'h1F);
    chk(mdc == 0 && mdio_oe == 0, "R7 idle bus quiet", 64'({mdc, mdio_oe}), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule